// File: doc/BRIEF.md
# Mitchell Logarithmic Approximate Multiplier

This block multiplies two unsigned operands through an approximate binary logarithm. It does not sum partial products. For each operand it finds the position of the highest set bit, which gives the characteristic k. It then takes the bits below that position as a fixed-point fraction x. The logarithm of the operand is approximated as k + x.

The two approximations are added, and the sum is turned back into an integer by a shift-only antilogarithm. The product is therefore deliberately inexact: it never exceeds the true product, and it is exact when both operands are powers of two. The block suits filters and other arithmetic where a small relative error is acceptable in exchange for no multiplier array and no lookup storage.

The core is combinational. A parameter adds an output register that captures a result only when the input strobe is high, and a valid flag that follows the strobe by one clock.

Top module: `mitchell_mult`

## Requirements
- R1: If either operand is zero, the product is exactly zero.
- R2: If both operands are powers of two, the product equals the true product.
- R3: Define the fraction of each nonzero operand v as xv = (v − 2^kv) · 2^(7−kv), a 7-bit integer in units of 1/128, where kv is the index of the highest set bit. Let s = xa + xb. When s < 128, the product is floor((128 + s) · 2^(ka+kb) / 128).
- R4: When s ≥ 128 (fraction sum of one or more), the product is floor(s · 2^(ka+kb+1) / 128).
- R5: For nonzero operands, the product is at least 1 and never greater than op_a · op_b.
- R6: With the output register enabled (default), out_valid equals the in_valid of the previous clock.
- R7: With the output register enabled, the product output changes only in the clock after in_valid was high; otherwise it holds its value.
- R8: While rst_n is low, out_valid and product are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are presented this cycle |
| op_a | input | 8 | Unsigned operand A |
| op_b | input | 8 | Unsigned operand B |
| out_valid | output | 1 | Product is valid |
| product | output | 16 | Approximate unsigned product |

## Verification
On every clock, the assertions check the properties that do not depend on the exact bit pattern of the approximation: a zero operand forces a zero result, the result never exceeds the true product and is never zero for nonzero inputs, powers of two multiply exactly, valid is delayed by one clock, and the result register holds while idle. The exact values in both fraction-sum branches can only be shown by the bench's reference model. The bench sweeps every operand pair, including the carry boundary where the two fractions sum to exactly one (for example 3 × 3 gives 8), and adds random idle gaps to exercise the hold behaviour.

// File: rtl/mitchell_mult.sv
module mitchell_mult #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           out_valid,
  output logic [2*W-1:0] product
);
  localparam int F  = W - 1;
  localparam int KW = $clog2(W);
  localparam int SW = KW + 2;
  localparam int PW = 3 * W;

  function automatic logic [KW-1:0] lead_one(input logic [W-1:0] v);
    logic [KW-1:0] pos;
    pos = '0;
    for (int i = 0; i < W; i++)
      if (v[i]) pos = KW'(i);
    return pos;
  endfunction

  function automatic logic [F-1:0] frac_of(input logic [W-1:0] v, input logic [KW-1:0] k);
    logic [W-1:0] t;
    t = v << (F - int'(k));
    return t[F-1:0];
  endfunction

  logic [KW-1:0]  ka, kb;
  logic [F-1:0]   xa, xb;
  logic [W-1:0]   fsum;
  logic           carry;
  logic [W-1:0]   mant;
  logic [SW-1:0]  sh;
  logic [PW-1:0]  wide;
  logic           is_zero;
  logic [2*W-1:0] comb_p;

  assign ka      = lead_one(op_a);
  assign kb      = lead_one(op_b);
  assign xa      = frac_of(op_a, ka);
  assign xb      = frac_of(op_b, kb);
  assign fsum    = {1'b0, xa} + {1'b0, xb};
  assign carry   = fsum[F];
  assign mant    = carry ? fsum : {1'b1, fsum[F-1:0]};
  assign sh      = SW'(ka) + SW'(kb) + SW'(carry);
  assign wide    = PW'(mant) << sh;
  assign is_zero = ~|op_a | ~|op_b;
  assign comb_p  = is_zero ? '0 : wide[F +: 2*W];

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          product   <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) product <= comb_p;
        end
      end

      // R1
      zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_a == '0 || op_b == '0) |=> product == '0);
      // R2
      pow2_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && $countones(op_a) == 1 && $countones(op_b) == 1
        |=> product == {{W{1'b0}}, $past(op_a)} * {{W{1'b0}}, $past(op_b)});
      // R5
      no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> product <= {{W{1'b0}}, $past(op_a)} * {{W{1'b0}}, $past(op_b)});
      // R5
      nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_a != '0 && op_b != '0 |=> product != '0);
      // R6
      valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));
      // R7
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(product));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign product   = comb_p;
    end
  endgenerate
endmodule

// File: tb/sim_mitchell_mult.sv
module sim_mitchell_mult;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic        out_valid;
  logic [15:0] product;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  int exp_p = 0;
  bit exp_v = 1'b0;
  string exp_tag = "R8";

  always #4 clk = ~clk;

  mitchell_mult u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
  );

  function automatic int msb_of(int v);
    int k = 0;
    for (int i = 0; i < 8; i++)
      if (v >= (1 << i)) k = i;
    return k;
  endfunction

  function automatic int model(int a, int b);
    int ka, kb, xa, xb, s;
    if (a == 0 || b == 0) return 0;
    ka = msb_of(a);
    kb = msb_of(b);
    xa = (a - (1 << ka)) * (1 << (7 - ka));
    xb = (b - (1 << kb)) * (1 << (7 - kb));
    s  = xa + xb;
    if (s < 128) return ((128 + s) * (1 << (ka + kb))) / 128;
    return (s * (1 << (ka + kb + 1))) / 128;
  endfunction

  function automatic bit is_pow2(int v);
    return v != 0 && (v & (v - 1)) == 0;
  endfunction

  function automatic string tag_of(int a, int b);
    int ka, kb, s;
    if (a == 0 || b == 0) return "R1";
    if (is_pow2(a) && is_pow2(b)) return "R2";
    ka = msb_of(a);
    kb = msb_of(b);
    s = (a - (1 << ka)) * (1 << (7 - ka)) + (b - (1 << kb)) * (1 << (7 - kb));
    return (s < 128) ? "R3" : "R4";
  endfunction

  task automatic check(bit cond, string req, int act, int expv, int a, int b);
    vectors++;
    if (!cond) begin
      miscompares++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, expv);
    end
  endtask

  task automatic apply(bit v, int a, int b);
    in_valid = v;
    op_a = 8'(a);
    op_b = 8'(b);
    @(posedge clk);
    exp_v = v;
    if (v) begin
      exp_p = model(a, b);
      exp_tag = tag_of(a, b);
    end else begin
      exp_tag = "R7";
    end
    @(negedge clk);
    check(out_valid == exp_v, "R6", int'(out_valid), int'(exp_v), a, b);
    check(int'(product) == exp_p, exp_tag, int'(product), exp_p, a, b);
    if (v && a != 0 && b != 0)
      check(int'(product) >= 1 && int'(product) <= a * b, "R5", int'(product), a * b, a, b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    op_a = 8'd55;
    op_b = 8'd99;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R8: outputs held at zero during reset even with valid input
    check(out_valid == 1'b0, "R8", int'(out_valid), 0, 55, 99);
    check(product == 16'd0, "R8", int'(product), 0, 55, 99);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    apply(1, 0, 77);      // R1
    apply(1, 200, 0);     // R1
    apply(1, 4, 8);       // R2 -> 32
    apply(1, 128, 128);   // R2 -> 16384
    apply(1, 1, 1);       // R2 -> 1
    apply(1, 5, 6);       // R3 -> 28
    apply(1, 3, 3);       // R4 boundary s=128 -> 8
    apply(1, 255, 255);   // R4 -> 65024
    apply(0, 13, 17);     // R7 hold
    apply(0, 0, 0);       // R7 hold
    apply(1, 7, 9);
    apply(1, 100, 200);

    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply(1, a, b);

    for (int n = 0; n < 3000; n++)
      apply(($urandom % 3) != 0, int'($urandom % 256), int'($urandom % 256));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule